// File: doc/BRIEF.md
# Circular Interrupt Queue with Global Event Register

This block collects interrupt entries from a producer, such as a channel engine, into a fixed-depth ring of slots. Each slot has a valid bit. The producer writes at its own pointer. The host services entries in order from the head of the ring: a pop returns the head payload and frees that slot. The producer may never write into a slot the host has not yet freed. When it tries, the new entry is thrown away and an overflow event is recorded, so the pending entries, including the slot where the ring wraps, are preserved.

Four global events sit in the upper nibble of an 8-bit event register:

| Bit | Event |
|-----|-------|
| 4 | queue overflow |
| 5 | entry posted |
| 6 | transmit underrun |
| 7 | receive overrun |

An 8-bit mask register has the same layout. One registered interrupt request line is raised from the masked events. A transmit underrun or a receive overrun is fatal to its own direction. It raises a halt output for all transmit or all receive channels. That halt stays until the host pulses the restart input for that direction. The other direction keeps running.

Top module: `irq_event_queue`

## Requirements
- R1: After a synchronous active-low reset, all slots are free (`head_valid`=0), the event and mask registers read 0x00, and `irq`, `tx_halt` and `rx_halt` are 0.
- R2: A post into a free slot stores the payload at the write pointer and marks it valid. Entries appear at the head in posting order. Both pointers wrap modulo DEPTH.
- R3: A post whose target slot is still valid is dropped. It sets event bit 4 (overflow) and leaves every stored entry unchanged.
- R4: Every accepted post sets event bit 5 (entry posted).
- R5: A pop with a valid head frees that slot and moves the head to the next slot. A pop while the head is free has no effect.
- R6: Writing the event register (`reg_sel`=0) clears each flag whose bit in the write data is 1. A 0 bit leaves that flag as it is. Writing the mask register (`reg_sel`=1) loads bits 7:4. Bits 3:0 of both registers always read 0.
- R7: When a hardware set and a host clear hit the same flag in the same cycle, the flag ends up set.
- R8: `irq` equals the OR of (event AND mask) from the previous cycle.
- R9: A `tx_underrun_evt` pulse sets event bit 6 and raises `tx_halt` on the next cycle. `rx_halt` is not affected.
- R10: An `rx_overrun_evt` pulse sets event bit 7 and raises `rx_halt` on the next cycle. `tx_halt` is not affected.
- R11: A halt stays asserted after its event flag is cleared. Only the restart pulse for that direction releases it, and a fatal event in the same cycle as a restart keeps it halted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| post_valid | input | 1 | Producer posts an entry this cycle |
| post_data | input | DATA_W | Entry payload |
| host_pop | input | 1 | Host consumes the head entry |
| head_valid | output | 1 | Head slot holds a pending entry |
| head_data | output | DATA_W | Payload of the head slot |
| reg_wr | input | 1 | Host register write strobe |
| reg_sel | input | 1 | 0 selects the event register, 1 selects the mask register |
| reg_wdata | input | 8 | Host write data |
| evt_q | output | 8 | Event register contents |
| mask_q | output | 8 | Mask register contents |
| irq | output | 1 | Registered interrupt request |
| tx_underrun_evt | input | 1 | Fatal transmit underrun pulse |
| rx_overrun_evt | input | 1 | Fatal receive overrun pulse |
| tx_restart | input | 1 | Host releases the transmit halt |
| rx_restart | input | 1 | Host releases the receive halt |
| tx_halt | output | 1 | Stop all transmit channels, line idle |
| rx_halt | output | 1 | Stop all receive channels, no data written |

## Verification
The bench builds the block with DEPTH=4 and DATA_W=8. This small ring lets a sequence of roughly sixty mixed post and pop steps pass through fill, overflow, drain and empty-pop phases several times, and it wraps both pointers repeatedly. A bench-side queue model predicts the result of every step. With only four maskable events, all sixteen mask values can be swept against two different flag patterns. The directed halt sequences cover each direction on its own, clearing a flag without a restart, and a restart that collides with a new fatal event.

// File: rtl/ieq_pkg.sv
// Package ieq_pkg
// Shared constants and types for the interrupt queue block.
// Assumes the four global events occupy the upper nibble of an 8-bit register.
package ieq_pkg;
    localparam int REG_W    = 8;
    localparam int NUM_EVT  = 4;
    localparam int EVT_LSB  = REG_W - NUM_EVT;
    localparam int BIT_QOVF = 4;
    localparam int BIT_POST = 5;
    localparam int BIT_TXUR = 6;
    localparam int BIT_RXOR = 7;

    // One bit per global event, MSB first in register order.
    typedef struct packed {
        logic rx_or;
        logic tx_ur;
        logic posted;
        logic q_ovf;
    } evt_vec_t;
endpackage

// File: rtl/ieq_slot_table.sv
// Module ieq_slot_table
// Ring of DEPTH payload slots, each with a valid bit.
// The producer writes at wr_ptr. A write into a valid slot is dropped and
// reported on 'dropped'. A host pop frees the head slot and advances rd_ptr.
// Both operations look at the state before the clock edge, so a post and a
// pop aimed at the same full slot report an overflow and free the slot.
module ieq_slot_table #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              post_valid,
    input  logic [DATA_W-1:0] post_data,
    input  logic              pop,
    output logic              head_valid,
    output logic [DATA_W-1:0] head_data,
    output logic              posted,
    output logic              dropped
);
    localparam int          PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  vld;
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              do_write;
    logic              do_pop;

    // Decide the producer and host actions from the current slot state.
    always_comb begin
        do_write = post_valid && !vld[wr_ptr];
        dropped  = post_valid &&  vld[wr_ptr];
        do_pop   = pop && vld[rd_ptr];
        posted   = do_write;
    end

    assign head_valid = vld[rd_ptr];
    assign head_data  = mem[rd_ptr];

    // Advance the write pointer after each accepted post, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_ptr <= '0;
        else if (do_write)
            wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    end

    // Advance the read pointer after each effective pop, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_ptr <= '0;
        else if (do_pop)
            rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    end

    // Store the payload of an accepted post.
    always_ff @(posedge clk) begin
        if (do_write)
            mem[wr_ptr] <= post_data;
    end

    // A write and a pop can never target the same slot (one needs it free,
    // the other needs it valid), so each slot has one owner per cycle.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Track whether slot g holds an entry the host has not consumed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                vld[g] <= 1'b0;
            else if (do_write && wr_ptr == PTR_W'(g))
                vld[g] <= 1'b1;
            else if (do_pop && rd_ptr == PTR_W'(g))
                vld[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/ieq_event_reg.sv
// Module ieq_event_reg
// Holds the four global event flags and their mask, and drives the irq line.
// A flag is cleared by a host write of 1 to its bit. A hardware set in the
// same cycle wins. The reserved low nibble is not stored and reads as zero.
module ieq_event_reg
    import ieq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  evt_vec_t         set_vec,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] evt_q,
    output logic [REG_W-1:0] mask_q,
    output logic             irq
);
    logic [NUM_EVT-1:0] flags;
    logic [NUM_EVT-1:0] mask4;
    logic [NUM_EVT-1:0] clr;

    // Form the write-1-to-clear vector for an event register write.
    always_comb begin
        clr = (wr_en && !wr_sel) ? wr_data[REG_W-1:EVT_LSB] : '0;
    end

    // Update the flags: clear first, then OR in hardware sets so that sets win.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= '0;
        else
            flags <= (flags & ~clr) | set_vec;
    end

    // Load the mask nibble on a mask register write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask4 <= '0;
        else if (wr_en && wr_sel)
            mask4 <= wr_data[REG_W-1:EVT_LSB];
    end

    // Register the interrupt request from the enabled flags.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= |(flags & mask4);
    end

    assign evt_q  = {flags, {EVT_LSB{1'b0}}};
    assign mask_q = {mask4, {EVT_LSB{1'b0}}};
endmodule

// File: rtl/ieq_halt_ctrl.sv
// Module ieq_halt_ctrl
// Halt latch for one traffic direction. A fatal event sets it and a restart
// pulse releases it. If both come in the same cycle, the latch stays set.
// Clearing the matching event flag has no effect on the latch.
module ieq_halt_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic fatal,
    input  logic restart,
    output logic halt
);
    // Hold the halt state; a fatal event has priority over a restart.
    always_ff @(posedge clk) begin
        if (!rst_n)
            halt <= 1'b0;
        else if (fatal)
            halt <= 1'b1;
        else if (restart)
            halt <= 1'b0;
    end
endmodule

// File: rtl/irq_event_queue.sv
// Module irq_event_queue
// Top level: the slot ring, the global event/mask registers and the two
// direction halt latches. The producer posts entries, the host pops them and
// accesses the registers. Fatal underrun and overrun stop their own direction.
// Assumes the event pulses and restarts are synchronous to clk.
module irq_event_queue
    import ieq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              post_valid,
    input  logic [DATA_W-1:0] post_data,
    input  logic              host_pop,
    output logic              head_valid,
    output logic [DATA_W-1:0] head_data,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        evt_q,
    output logic [7:0]        mask_q,
    output logic              irq,
    input  logic              tx_underrun_evt,
    input  logic              rx_overrun_evt,
    input  logic              tx_restart,
    input  logic              rx_restart,
    output logic              tx_halt,
    output logic              rx_halt
);
    localparam int NUM_DIR = 2;

    logic             posted;
    logic             dropped;
    evt_vec_t         set_vec;
    logic [NUM_DIR-1:0] fatal_v;
    logic [NUM_DIR-1:0] restart_v;
    logic [NUM_DIR-1:0] halt_v;

    ieq_slot_table #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .post_valid (post_valid),
        .post_data  (post_data),
        .pop        (host_pop),
        .head_valid (head_valid),
        .head_data  (head_data),
        .posted     (posted),
        .dropped    (dropped)
    );

    // Gather the hardware event sources in register bit order.
    always_comb begin
        set_vec.q_ovf  = dropped;
        set_vec.posted = posted;
        set_vec.tx_ur  = tx_underrun_evt;
        set_vec.rx_or  = rx_overrun_evt;
    end

    ieq_event_reg u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .wr_en   (reg_wr),
        .wr_sel  (reg_sel),
        .wr_data (reg_wdata),
        .evt_q   (evt_q),
        .mask_q  (mask_q),
        .irq     (irq)
    );

    assign fatal_v   = {rx_overrun_evt, tx_underrun_evt};
    assign restart_v = {rx_restart, tx_restart};

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        ieq_halt_ctrl u_halt (
            .clk     (clk),
            .rst_n   (rst_n),
            .fatal   (fatal_v[d]),
            .restart (restart_v[d]),
            .halt    (halt_v[d])
        );
    end

    assign tx_halt = halt_v[0];
    assign rx_halt = halt_v[1];
endmodule

// File: rtl/irq_event_queue_chk.sv
// Module irq_event_queue_chk
// Temporal checks on the ports of irq_event_queue, attached with bind.
module irq_event_queue_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       post_valid,
    input logic [7:0] evt_q,
    input logic [7:0] mask_q,
    input logic       irq,
    input logic       tx_underrun_evt,
    input logic       rx_overrun_evt,
    input logic       tx_restart,
    input logic       rx_restart,
    input logic       tx_halt,
    input logic       rx_halt
);
    // The reserved nibbles never read as anything but zero.
    assert_rsvd_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q[3:0] == 4'h0) && (mask_q[3:0] == 4'h0));

    // A post always leaves either the overflow flag or the posted flag set.
    assert_post_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        post_valid |=> (evt_q[4] || evt_q[5]));

    // The interrupt line follows the masked events one cycle later.
    assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(evt_q & mask_q))));

    // A hardware set is never lost to a concurrent clear.
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underrun_evt |=> evt_q[6]);

    // Transmit underrun halts transmission on the next cycle.
    assert_tx_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underrun_evt |=> tx_halt);

    // Receive overrun halts reception on the next cycle.
    assert_rx_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun_evt |=> (rx_halt && evt_q[7]));

    // Without a restart, a halt is never released.
    assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_halt && !tx_restart) |=> tx_halt);

    assert_rx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_halt && !rx_restart) |=> rx_halt);
endmodule

bind irq_event_queue irq_event_queue_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .post_valid      (post_valid),
    .evt_q           (evt_q),
    .mask_q          (mask_q),
    .irq             (irq),
    .tx_underrun_evt (tx_underrun_evt),
    .rx_overrun_evt  (rx_overrun_evt),
    .tx_restart      (tx_restart),
    .rx_restart      (rx_restart),
    .tx_halt         (tx_halt),
    .rx_halt         (rx_halt)
);

// File: tb/irq_event_queue_bench.sv
// Bench for irq_event_queue with DEPTH=4 and DATA_W=8. Inputs are driven and
// outputs sampled on the falling edge.
module irq_event_queue_bench;
    localparam int DEPTH  = 4;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              post_valid;
    logic [DATA_W-1:0] post_data;
    logic              host_pop;
    logic              head_valid;
    logic [DATA_W-1:0] head_data;
    logic              reg_wr;
    logic              reg_sel;
    logic [7:0]        reg_wdata;
    logic [7:0]        evt_q;
    logic [7:0]        mask_q;
    logic              irq;
    logic              tx_underrun_evt;
    logic              rx_overrun_evt;
    logic              tx_restart;
    logic              rx_restart;
    logic              tx_halt;
    logic              rx_halt;

    int total = 0;
    int bad   = 0;

    // Bench-side model of the ring.
    logic [DATA_W-1:0] m_mem [DEPTH];
    logic [DEPTH-1:0]  m_vld;
    int                m_wr;
    int                m_rd;

    always #4 clk = ~clk;

    irq_event_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_irq_event_queue (
        .clk (clk), .rst_n (rst_n),
        .post_valid (post_valid), .post_data (post_data),
        .host_pop (host_pop), .head_valid (head_valid), .head_data (head_data),
        .reg_wr (reg_wr), .reg_sel (reg_sel), .reg_wdata (reg_wdata),
        .evt_q (evt_q), .mask_q (mask_q), .irq (irq),
        .tx_underrun_evt (tx_underrun_evt), .rx_overrun_evt (rx_overrun_evt),
        .tx_restart (tx_restart), .rx_restart (rx_restart),
        .tx_halt (tx_halt), .rx_halt (rx_halt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        post_valid = 0; post_data = '0; host_pop = 0;
        reg_wr = 0; reg_sel = 0; reg_wdata = '0;
        tx_underrun_evt = 0; rx_overrun_evt = 0; tx_restart = 0; rx_restart = 0;
    endtask

    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_vld = '0; m_wr = 0; m_rd = 0;
    endtask

    task automatic post(input logic [DATA_W-1:0] d);
        post_valid = 1; post_data = d;
        step();
    endtask

    task automatic reg_write(input logic sel, input logic [7:0] d);
        reg_wr = 1; reg_sel = sel; reg_wdata = d;
        step();
    endtask

    // Watchdog: counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 head_valid", head_valid, 0);
        chk("R1 evt", evt_q, 0);
        chk("R1 mask", mask_q, 0);
        chk("R1 irq", irq, 0);
        chk("R1 tx_halt", tx_halt, 0);
        chk("R1 rx_halt", rx_halt, 0);

        // R2 R3 R4 R5 R7: mixed post/pop sweep against the model. Bits 5:4
        // are cleared every step, in the same cycle as any new set.
        for (int k = 0; k < 64; k++) begin
            logic p, q, e_ovf, e_post;
            p = ((k / 8) % 2 == 0) ? (k % 4 != 3) : (k % 4 == 0);
            q = ((k / 8) % 2 == 0) ? (k % 3 == 0) : (k % 4 != 0);
            post_valid = p; post_data = DATA_W'(k + 1);
            host_pop = q; reg_wr = 1; reg_sel = 0; reg_wdata = 8'h30;
            e_ovf  = p && m_vld[m_wr];
            e_post = p && !m_vld[m_wr];
            if (q && m_vld[m_rd]) begin
                m_vld[m_rd] = 0; m_rd = (m_rd + 1) % DEPTH;
            end
            if (e_post) begin
                m_mem[m_wr] = DATA_W'(k + 1); m_vld[m_wr] = 1; m_wr = (m_wr + 1) % DEPTH;
            end
            step();
            chk("R2 R5 head_valid", head_valid, m_vld[m_rd]);
            if (m_vld[m_rd]) chk("R2 head_data", head_data, m_mem[m_rd]);
            chk("R3 R7 overflow bit4", evt_q[4], e_ovf);
            chk("R4 R7 posted bit5", evt_q[5], e_post);
        end

        // R3: overflow keeps every stored entry, including the wrap slot.
        do_reset();
        for (int i = 0; i < DEPTH; i++) post(DATA_W'(8'h10 + i));
        chk("R4 posted", evt_q, 8'h20);
        post(8'h99);
        chk("R3 overflow", evt_q, 8'h30);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R3 kept head_data", head_data, DATA_W'(8'h10 + i));
            host_pop = 1; step();
        end
        chk("R3 drained", head_valid, 0);

        // R5: a pop on a free head does not move the head.
        do_reset();
        host_pop = 1; step();
        chk("R5 empty pop", head_valid, 0);
        post(8'hAB);
        chk("R5 head after empty pop", head_data, 8'hAB);
        host_pop = 1; step();
        host_pop = 1; step();
        chk("R5 empty again", head_valid, 0);
        post(8'hCD);
        chk("R5 head valid", head_valid, 1);
        chk("R5 head data", head_data, 8'hCD);

        // R6: write-1-to-clear, write-0 no effect, reserved bits read zero.
        do_reset();
        for (int i = 0; i <= DEPTH; i++) post(DATA_W'(i));
        chk("R6 flags set", evt_q, 8'h30);
        reg_write(0, 8'h0F);
        chk("R6 write0 no effect", evt_q, 8'h30);
        reg_write(0, 8'h10);
        chk("R6 clear bit4", evt_q, 8'h20);
        reg_write(1, 8'hFF);
        chk("R6 mask reserved", mask_q, 8'hF0);
        reg_write(0, 8'h20);
        chk("R6 clear bit5", evt_q, 8'h00);

        // R8: sweep every mask against two flag patterns.
        do_reset();
        for (int i = 0; i <= DEPTH; i++) post(DATA_W'(i));
        tx_underrun_evt = 1; rx_overrun_evt = 1; step();
        chk("R9 R10 all flags", evt_q, 8'hF0);
        for (int m = 0; m < 16; m++) begin
            reg_write(1, {4'(m), 4'h0});
            step();
            chk("R8 irq all flags", irq, (m != 0));
        end
        reg_write(0, 8'hB0);
        chk("R6 only bit6 left", evt_q, 8'h40);
        for (int m = 0; m < 16; m++) begin
            reg_write(1, {4'(m), 4'h0});
            step();
            chk("R8 irq bit6 only", irq, m[2]);
        end

        // R9 R11: transmit halt independence, hold and restart.
        do_reset();
        tx_underrun_evt = 1; step();
        chk("R9 tx_halt", tx_halt, 1);
        chk("R9 rx_halt", rx_halt, 0);
        chk("R9 flag", evt_q, 8'h40);
        reg_write(0, 8'h40);
        chk("R11 flag cleared", evt_q, 8'h00);
        chk("R11 tx still halted", tx_halt, 1);
        tx_restart = 1; step();
        chk("R11 tx released", tx_halt, 0);
        tx_underrun_evt = 1; tx_restart = 1; step();
        chk("R11 fatal beats restart", tx_halt, 1);

        // R10: receive halt independence.
        rx_overrun_evt = 1; step();
        chk("R10 rx_halt", rx_halt, 1);
        chk("R10 flag", evt_q[7], 1);
        rx_restart = 1; step();
        chk("R10 R11 rx released", rx_halt, 0);
        chk("R10 tx unaffected", tx_halt, 1);

        // R7: set and clear of bit7 in the same cycle.
        reg_write(0, 8'h80);
        chk("R7 cleared", evt_q[7], 0);
        rx_overrun_evt = 1; reg_wr = 1; reg_sel = 0; reg_wdata = 8'h80; step();
        chk("R7 set wins", evt_q[7], 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule